// File: doc/BRIEF.md
# SCL Clock Generator with Prescaler

This block derives the serial clock of a two-wire bus master from the system clock. An 8-bit prescale value divides the system clock into a slower module tick. Two 16-bit counts then set how long SCL stays low and how long it stays high, measured in module ticks. Each phase is also stretched by a fixed extra amount that depends on the prescale value: 7 ticks when the prescale is 0, 6 ticks when it is 1, and 5 ticks when it is larger.

The configuration inputs are captured only while the block is disabled. When `enable` rises, SCL is pulled low first and the low/high cycle repeats until `enable` drops. At each SCL transition a one-cycle strobe is issued, so that a neighbouring data shifter can change SDA while SCL is low and sample it after SCL rises. Clock stretching by targets and the rest of the protocol engine belong to other blocks.

Top module: `scl_timing_gen`

## Requirements
- R1: During and directly after reset, `sclOut` is 1 and both `fallStrobe` and `riseStrobe` are 0.
- R2: While `enable` is 0, `sclOut` is 1 from the next cycle on, no strobe is issued, and all counters are cleared, so the next enable always starts a fresh low phase.
- R3: In the first cycle after the rising clock edge where `enable` is first sampled at 1, `sclOut` is 0 and `fallStrobe` is 1.
- R4: The low phase lasts (lowCount + d) x (prescale + 1) system clock cycles, measured from the falling strobe to the rising strobe.
- R5: The high phase lasts (highCount + d) x (prescale + 1) system clock cycles, measured from the rising strobe to the next falling strobe.
- R6: The extra count d is 7 for prescale 0, 6 for prescale 1, and 5 for every prescale of 2 or more, so no phase is ever shorter than 5 cycles.
- R7: `fallStrobe` is 1 for exactly the one cycle in which `sclOut` has just gone from 1 to 0 during a run, `riseStrobe` likewise for a change from 0 to 1, and the two are never 1 together.
- R8: `prescale`, `lowCount` and `highCount` are captured on every cycle in which `enable` is 0; changes to them while `enable` is 1 have no effect on the running phases.
- R9: The extreme setting prescale 255 with both counts 0 gives phases of 5 x 256 = 1280 cycles each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the clock when 1; clears and captures configuration when 0 |
| prescale | input | 8 | System clocks per module tick, minus one |
| lowCount | input | 16 | Programmed low phase length in module ticks, before the extra d |
| highCount | input | 16 | Programmed high phase length in module ticks, before the extra d |
| sclOut | output | 1 | SCL level to drive: 0 pulls the line low, 1 releases it |
| fallStrobe | output | 1 | One-cycle pulse with the start of each low phase |
| riseStrobe | output | 1 | One-cycle pulse with the start of each high phase |

## Verification
The bound checker watches on every cycle that SCL is released after a disable, that a new run opens with a falling strobe, that each strobe matches a real transition of SCL in its direction, that the strobes never coincide, and that no low phase ends before the 5-cycle floor. The exact phase lengths, the choice of d for each prescale range, the capture of configuration only while disabled and the extreme-divide case are shown only by the bench scenarios, which measure the spacing between strobes against lengths computed from the formula.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  localparam int PS_W  = 8;
  localparam int CNT_W = 16;
  localparam int LIM_W = CNT_W + 1;

  // Control to datapath strobes.
  typedef struct packed {
    logic clear;    // hold counters at zero, capture configuration
    logic restart;  // start a new phase: zero both counters
    logic selHigh;  // current phase is the high phase
  } ctlStrobes_t;

  // Extra ticks added to each phase for a given prescale.
  function automatic logic [2:0] extraTicks(input logic [PS_W-1:0] ps);
    if (ps == '0)              return 3'd7;
    else if (ps == PS_W'(1))   return 3'd6;
    else                       return 3'd5;
  endfunction

endpackage

// File: rtl/scl_gen_dp.sv
module scl_gen_dp
  import scl_gen_pkg::*;
#(
  parameter int PsW  = PS_W,
  parameter int CntW = CNT_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobes_t     ctl,
  input  logic [PsW-1:0]  prescale,
  input  logic [CntW-1:0] lowCount,
  input  logic [CntW-1:0] highCount,
  output logic            phaseDone
);

  localparam int LimW = CntW + 1;

  logic [PsW-1:0]  psCfg;
  logic [CntW-1:0] lowCfg, highCfg;
  logic [PsW-1:0]  psCnt;
  logic [LimW-1:0] phCnt;
  logic [LimW-1:0] limit;
  logic            tick;

  always_comb begin
    limit = {1'b0, (ctl.selHigh ? highCfg : lowCfg)}
          + LimW'(extraTicks(PS_W'(psCfg)));
    tick  = (psCnt == psCfg);
    phaseDone = tick && (phCnt == limit - LimW'(1));
  end

  // Configuration is captured only while the control holds clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCfg   <= '0;
      lowCfg  <= '0;
      highCfg <= '0;
    end else if (ctl.clear) begin
      psCfg   <= prescale;
      lowCfg  <= lowCount;
      highCfg <= highCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
      phCnt <= '0;
    end else if (ctl.clear || ctl.restart) begin
      psCnt <= '0;
      phCnt <= '0;
    end else if (tick) begin
      psCnt <= '0;
      phCnt <= phCnt + LimW'(1);
    end else begin
      psCnt <= psCnt + PsW'(1);
    end
  end

endmodule

// File: rtl/scl_gen_ctrl.sv
module scl_gen_ctrl
  import scl_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        phaseDone,
  output ctlStrobes_t ctl,
  output logic        sclOut,
  output logic        fallStrobe,
  output logic        riseStrobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} sclState_t;

  sclState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    ctl.clear   = !enable;
    ctl.restart = 1'b0;
    ctl.selHigh = (state == ST_HIGH);
    if (!enable) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stateNext   = ST_LOW;
          ctl.restart = 1'b1;
        end
        ST_LOW: if (phaseDone) begin
          stateNext   = ST_HIGH;
          ctl.restart = 1'b1;
        end
        ST_HIGH: if (phaseDone) begin
          stateNext   = ST_LOW;
          ctl.restart = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      fallStrobe <= 1'b0;
      riseStrobe <= 1'b0;
    end else begin
      state      <= stateNext;
      fallStrobe <= (stateNext == ST_LOW)  && (state != ST_LOW);
      riseStrobe <= (stateNext == ST_HIGH) && (state == ST_LOW);
    end
  end

  assign sclOut = (state != ST_LOW);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [PS_W-1:0]   prescale,
  input  logic [CNT_W-1:0]  lowCount,
  input  logic [CNT_W-1:0]  highCount,
  output logic              sclOut,
  output logic              fallStrobe,
  output logic              riseStrobe
);

  ctlStrobes_t ctl;
  logic        phaseDone;

  scl_gen_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .phaseDone  (phaseDone),
    .ctl        (ctl),
    .sclOut     (sclOut),
    .fallStrobe (fallStrobe),
    .riseStrobe (riseStrobe)
  );

  scl_gen_dp #(.PsW(PS_W), .CntW(CNT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .prescale  (prescale),
    .lowCount  (lowCount),
    .highCount (highCount),
    .phaseDone (phaseDone)
  );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclOut,
  input logic fallStrobe,
  input logic riseStrobe
);

  // Cycles since the last falling strobe, saturating.
  logic [15:0] lowLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lowLen <= '0;
    else if (fallStrobe)       lowLen <= 16'd1;
    else if (lowLen != 16'hFFFF) lowLen <= lowLen + 16'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (sclOut && !fallStrobe && !riseStrobe));

  p_idle_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclOut && !fallStrobe && !riseStrobe));

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |=> (!sclOut && fallStrobe));

  p_fall_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe |-> (!sclOut && $past(sclOut)));

  p_rise_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe |-> (sclOut && !$past(sclOut)));

  p_fell_has_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOut) |-> fallStrobe);

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(fallStrobe && riseStrobe));

  p_min_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe |-> (lowLen >= 16'd5));

endmodule

bind scl_timing_gen scl_timing_gen_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .sclOut     (sclOut),
  .fallStrobe (fallStrobe),
  .riseStrobe (riseStrobe)
);

// File: tb/test_scl_timing_gen.sv
`timescale 1ns/1ps
module test_scl_timing_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  prescale = '0;
  logic [15:0] lowCount = '0;
  logic [15:0] highCount = '0;
  logic        sclOut, fallStrobe, riseStrobe;

  always #2.5 clk = ~clk;  // 200 MHz

  scl_timing_gen i_scl_timing_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .prescale(prescale),
    .lowCount(lowCount), .highCount(highCount),
    .sclOut(sclOut), .fallStrobe(fallStrobe), .riseStrobe(riseStrobe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { bit isRise; int len; string req; } expItem_t;
  expItem_t expQ[$];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures strobe spacing and compares with the queue.
  int cyc = 0;
  int prevCyc = 0;
  bit havePrev = 0;
  always @(negedge clk) begin
    cyc++;
    if (!enable || !rstN) begin
      havePrev = 0;
    end else if (fallStrobe || riseStrobe) begin
      if (havePrev) begin
        if (expQ.size() == 0) begin
          check(0, "R7 unexpected strobe", cyc - prevCyc, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(riseStrobe == e.isRise, {e.req, " edge kind"},
                int'(riseStrobe), int'(e.isRise));
          check((cyc - prevCyc) == e.len, e.req, cyc - prevCyc, e.len);
        end
      end
      havePrev = 1;
      prevCyc = cyc;
    end
  end

  function automatic int dOf(int p);
    return (p == 0) ? 7 : (p == 1) ? 6 : 5;
  endfunction

  // Driver: program while disabled, run two full periods.
  task automatic runCfg(int p, int l, int h, bit poke, string tag);
    int lowLen, highLen;
    @(negedge clk);
    enable = 0;
    prescale = 8'(p); lowCount = 16'(l); highCount = 16'(h);
    repeat (3) @(negedge clk);
    enable = 1;
    lowLen  = (l + dOf(p)) * (p + 1);
    highLen = (h + dOf(p)) * (p + 1);
    for (int k = 0; k < 2; k++) begin
      expQ.push_back('{1'b1, lowLen,  {tag, " R4 low phase"}});
      expQ.push_back('{1'b0, highLen, {tag, " R5 high phase"}});
    end
    @(negedge clk);
    // R3: first cycle after enable is sampled shows a falling strobe
    check(!sclOut && fallStrobe, {tag, " R3 start low"},
          int'(sclOut), 0);
    if (poke) begin
      // R8: change config mid-run; expected lengths stay the old ones
      prescale = 8'(p + 3); lowCount = 16'(l + 9); highCount = 16'(h + 4);
    end
    for (int w = 0; w < 20000 && expQ.size() != 0; w++) @(negedge clk);
    check(expQ.size() == 0, {tag, " queue drained"}, expQ.size(), 0);
    expQ.delete();
    enable = 0;
    @(negedge clk);
    @(negedge clk);
    check(sclOut && !fallStrobe && !riseStrobe, {tag, " R2 released"},
          int'(sclOut), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sclOut && !fallStrobe && !riseStrobe, "R1 reset state",
          int'(sclOut), 1);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(sclOut && !fallStrobe && !riseStrobe, "R1 after release",
          int'(sclOut), 1);

    // R2: disabled for many cycles, no activity
    begin
      int seen = 0;
      lowCount = 16'd1; highCount = 16'd1;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (!sclOut || fallStrobe || riseStrobe) seen++;
      end
      check(seen == 0, "R2 idle while disabled", seen, 0);
    end

    runCfg(0, 3, 2, 0, "R6 d=7");
    runCfg(1, 2, 4, 0, "R6 d=6");
    runCfg(3, 1, 0, 0, "R6 d=5");
    runCfg(2, 0, 6, 1, "R8 ignore changes");
    runCfg(255, 0, 0, 0, "R9 max divide");

    // R2: disable mid-phase, then re-enable restarts from a fresh low phase
    runCfg(0, 40, 40, 0, "R2 warmup");
    enable = 1;
    repeat (17) @(negedge clk);
    enable = 0;
    @(negedge clk);
    check(sclOut && !fallStrobe && !riseStrobe, "R2 abort mid-phase",
          int'(sclOut), 1);
    runCfg(0, 40, 40, 0, "R2 fresh restart");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule